// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Cycle Controller

This block sits between a clocked host and an asynchronous static RAM that holds 131,072 bytes. The host places one single-byte read or write request at a time on a valid/ready handshake. The controller turns each request into a cycle on the memory pins with correct timing. The memory pins are a 17-bit address, a low-true chip select paired with a high-true chip select, a low-true output enable, a low-true write strobe and an 8-bit bidirectional data bus. When a request finishes, the controller pulses a one-clock completion flag. For reads, it also presents the captured byte.

Every minimum time is a nanosecond parameter, as is the clock period. Each phase is converted to a whole number of clocks equal to the ceiling of the minimum divided by the period, and never less than one clock. At the 4 ns default period the phases are: setup 1, write pulse 14, write recovery 3, read access 18 and bus release 7. The controller drives the data bus only while the write strobe is low. It holds off a write until the memory has had time to release the bus after a read. Between requests it leaves the chip deselected, so the memory falls into its own standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and whenever `req_ready` is high, `mem_cs_n`=1, `mem_cs2`=0, `mem_oe_n`=1 and `mem_we_n`=1, and `rsp_done`=0 during reset.
- R2: A write drives `mem_cs_n` low, `mem_cs2` high and `mem_we_n` low with `mem_oe_n` high. `mem_addr` stays stable while `mem_we_n` is low, the bus carries the request's write byte, and `mem_oe_n` and `mem_we_n` are never low together.
- R3: The write strobe stays low for at least max(ceil(t_wp/T), ceil(t_dw/T)) clocks, and the write data is stable on the bus for at least ceil(t_dw/T) clocks before the strobe rises.
- R4: The address and the chip selects are present for at least one clock before the write strobe falls. With no bus release pending, `rsp_done` rises exactly AS+WP+REC clocks after the accepting edge, where REC = max(1, ceil(t_wc/T) − AS − WP).
- R5: A read holds the chip selected, `mem_oe_n` low and `mem_we_n` high for RD = max(ceil(t_rc/T), ceil(t_aa/T), ceil(t_oe/T)) clocks. The bus is sampled on the last of those clocks into `rsp_rdata`, and `rsp_done` rises RD clocks after the accepting edge.
- R6: The controller drives `mem_dq` only while `mem_we_n` is low in a write pulse, so reads return the memory's byte uncorrupted.
- R7: After `mem_oe_n` rises at the end of a read, `mem_we_n` does not fall for at least ceil(t_hz/T) clocks. A write accepted inside that window takes longer than one that is not.
- R8: A request is taken on an edge where `req_valid` and `req_ready` are both high. `req_ready` stays low until completion, and `rsp_done` is high for exactly one clock per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle and able to take a request |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| mem_addr | output | 17 | Memory address pins |
| mem_cs_n | output | 1 | Low-true chip select |
| mem_cs2 | output | 1 | High-true chip select |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_dq | inout | 8 | Shared data bus |

## Verification
With nothing pending, a write completes 18 clocks after the accepting edge and a read also completes 18 clocks after it, with the read byte valid in the same cycle as the completion pulse. The bench counts rising edges from acceptance and samples 1 ns after each edge, so it compares the exact clock on which `rsp_done` first appears. It then samples once more on the following edge to confirm the pulse has gone. A behavioural memory samples the pins on falling edges and measures each strobe's width, the data stability window and the address setup and hold in whole clocks. It drives read data only once the access count is reached, so a read that samples one clock early captures the wrong byte. It also tracks the seven-clock release window after every read and reports any write strobe that falls inside it.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_SETUP,
    ST_PULSE,
    ST_RECOV,
    ST_READ
  } sram_state_e;

  // Whole clocks covering a nanosecond minimum, never fewer than one.
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

  // Phase lengths rely on one decrement per clock (R3)
  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  sram_state_e st_d,
  input  logic [DW-1:0] wdata,
  output logic        cs_n,
  output logic        cs2,
  output logic        oe_n,
  output logic        we_n,
  output logic [DW-1:0] dq_in,
  inout  wire  [DW-1:0] dq
);

  logic sel_d, oe_d, we_d, drv_d;
  logic cs_n_q, cs2_q, oe_n_q, we_n_q, drv_q;

  // Next strobe levels, decoded from the next state so pins change glitch-free.
  always_comb begin
    sel_d = (st_d == ST_SETUP) || (st_d == ST_PULSE) ||
            (st_d == ST_RECOV) || (st_d == ST_READ);
    oe_d  = (st_d == ST_READ);
    we_d  = (st_d == ST_PULSE);
    drv_d = (st_d == ST_PULSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      cs2_q  <= 1'b0;
      oe_n_q <= 1'b1;
      we_n_q <= 1'b1;
      drv_q  <= 1'b0;
    end else begin
      cs_n_q <= !sel_d;
      cs2_q  <= sel_d;
      oe_n_q <= !oe_d;
      we_n_q <= !we_d;
      drv_q  <= drv_d;
    end
  end

  assign cs_n  = cs_n_q;
  assign cs2   = cs2_q;
  assign oe_n  = oe_n_q;
  assign we_n  = we_n_q;
  assign dq    = drv_q ? wdata : {DW{1'bz}};
  assign dq_in = dq;

  // Bus is driven only under a low write strobe with output enable off (R6)
  p_drive_in_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> (!we_n_q && oe_n_q && !cs_n_q));

  // Both chip selects always move together (R2)
  p_cs_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q != cs2_q);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_NS  = 4,
  parameter int unsigned T_AS_NS = 0,
  parameter int unsigned T_WP_NS = 55,
  parameter int unsigned T_DW_NS = 30,
  parameter int unsigned T_WC_NS = 70,
  parameter int unsigned T_RC_NS = 70,
  parameter int unsigned T_AA_NS = 70,
  parameter int unsigned T_OE_NS = 35,
  parameter int unsigned T_HZ_NS = 25,
  parameter int unsigned AW      = 17,
  parameter int unsigned DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_cs2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  inout  wire  [DW-1:0] mem_dq
);

  localparam int unsigned AS_C  = ns_to_cycles(T_AS_NS, CLK_NS);
  localparam int unsigned WP_C  = umax(ns_to_cycles(T_WP_NS, CLK_NS),
                                       ns_to_cycles(T_DW_NS, CLK_NS));
  localparam int unsigned WC_C  = ns_to_cycles(T_WC_NS, CLK_NS);
  localparam int unsigned REC_C = (WC_C > AS_C + WP_C) ? (WC_C - AS_C - WP_C) : 1;
  localparam int unsigned RD_C  = umax(ns_to_cycles(T_RC_NS, CLK_NS),
                                  umax(ns_to_cycles(T_AA_NS, CLK_NS),
                                       ns_to_cycles(T_OE_NS, CLK_NS)));
  localparam int unsigned HZ_C  = ns_to_cycles(T_HZ_NS, CLK_NS);
  localparam int unsigned MAX_C = umax(umax(AS_C, WP_C), umax(umax(REC_C, RD_C), HZ_C));
  localparam int unsigned TW    = $clog2(MAX_C + 1);

  localparam logic [TW-1:0] AS_L  = TW'(AS_C - 1);
  localparam logic [TW-1:0] WP_L  = TW'(WP_C - 1);
  localparam logic [TW-1:0] REC_L = TW'(REC_C - 1);
  localparam logic [TW-1:0] RD_L  = TW'(RD_C - 1);
  localparam logic [TW-1:0] HZ_L  = TW'(HZ_C);

  sram_state_e   st_q, st_d;
  logic          t_load, t_zero;
  logic [TW-1:0] t_val;
  logic          g_load, g_zero, gap_busy;
  logic          accept, finish, capture;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, dq_in;
  logic          done_q;

  // Next-state and phase-timer load decisions.
  always_comb begin
    st_d    = st_q;
    t_load  = 1'b0;
    t_val   = '0;
    g_load  = 1'b0;
    accept  = 1'b0;
    finish  = 1'b0;
    capture = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            if (gap_busy) begin
              st_d = ST_TURN;
            end else begin
              st_d   = ST_SETUP;
              t_load = 1'b1;
              t_val  = AS_L;
            end
          end else begin
            st_d   = ST_READ;
            t_load = 1'b1;
            t_val  = RD_L;
          end
        end
      end
      ST_TURN: begin
        if (!gap_busy) begin
          st_d   = ST_SETUP;
          t_load = 1'b1;
          t_val  = AS_L;
        end
      end
      ST_SETUP: begin
        if (t_zero) begin
          st_d   = ST_PULSE;
          t_load = 1'b1;
          t_val  = WP_L;
        end
      end
      ST_PULSE: begin
        if (t_zero) begin
          st_d   = ST_RECOV;
          t_load = 1'b1;
          t_val  = REC_L;
        end
      end
      ST_RECOV: begin
        if (t_zero) begin
          st_d   = ST_IDLE;
          finish = 1'b1;
        end
      end
      ST_READ: begin
        if (t_zero) begin
          st_d    = ST_IDLE;
          finish  = 1'b1;
          capture = 1'b1;
          g_load  = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= dq_in;
    end
  end

  sram_phase_timer #(.CNT_W(TW)) phase_tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  sram_phase_timer #(.CNT_W(TW)) release_tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (g_load),
    .load_val (HZ_L),
    .zero     (g_zero)
  );

  assign gap_busy = !g_zero;

  sram_pin_drv #(.DW(DW)) pins_i (
    .clk   (clk),
    .rst_n (rst_n),
    .st_d  (st_d),
    .wdata (wdata_q),
    .cs_n  (mem_cs_n),
    .cs2   (mem_cs2),
    .oe_n  (mem_oe_n),
    .we_n  (mem_we_n),
    .dq_in (dq_in),
    .dq    (mem_dq)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
  assign mem_addr  = addr_q;

  // Idle means deselected with every strobe high (R1)
  p_ready_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs2 && mem_oe_n && mem_we_n));

  // Output enable and write strobe never overlap (R2)
  p_strobe_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // Address holds through the write pulse (R2)
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  // Strobe stays high while the memory may still drive the bus (R7)
  p_release_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gap_busy |-> mem_we_n);

  // Completion is a single-clock pulse (R8)
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

  localparam int P = 4;

  function automatic int cd(int ns);
    int c;
    c = (ns + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int AS_C  = cd(0);
  localparam int DW_C  = cd(30);
  localparam int WP_C  = (cd(55) > cd(30)) ? cd(55) : cd(30);
  localparam int WC_C  = cd(70);
  localparam int RC_C  = cd(70);
  localparam int ACC_C = (cd(70) > cd(35)) ? cd(70) : cd(35);
  localparam int RD_C  = (RC_C > ACC_C) ? RC_C : ACC_C;
  localparam int HZ_C  = cd(25);
  localparam int WR_LAT = (WC_C > AS_C + WP_C) ? WC_C : AS_C + WP_C + 1;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rsp_done;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_cs_n, mem_cs2, mem_oe_n, mem_we_n;
  wire  [7:0]  mem_dq;

  int checks = 0;
  int errors = 0;

  sram_async_ctrl #(.CLK_NS(P)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs2(mem_cs2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq(mem_dq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural memory with timing monitor, sampled on falling edges.
  logic [7:0]  mem [int];
  logic [7:0]  cur_wdata;
  logic        mdl_drv;
  logic [7:0]  mdl_val;
  bit          pw, pr, pcs;
  logic [16:0] pa;
  logic [7:0]  pdq;
  int          we_cnt, dstab, rd_cnt, hz_left;

  assign mem_dq = mdl_drv ? mdl_val : 8'hzz;

  initial begin
    mdl_drv = 1'b0; mdl_val = 8'h00; cur_wdata = 8'h00;
    pw = 0; pr = 0; pcs = 0; pa = '0; pdq = '0;
    we_cnt = 0; dstab = 0; rd_cnt = 0; hz_left = 0;
  end

  always @(negedge clk) begin
    bit cs, wr, rd;
    if (rst_n) begin
      cs = !mem_cs_n && mem_cs2;
      wr = cs && !mem_we_n;
      rd = cs && mem_we_n && !mem_oe_n;
      if (!mem_oe_n && !mem_we_n) chk(0, "R2 output enable overlaps write strobe", 1, 0);
      if (req_ready && (!mem_cs_n || mem_cs2 || !mem_oe_n || !mem_we_n))
        chk(0, "R1 pins not in standby while ready", {mem_cs_n, mem_cs2, mem_oe_n, mem_we_n}, 4'b1011);
      if (wr) begin
        if (!pw) begin
          chk(pcs && pa == mem_addr, "R4 address and selects set up before strobe", int'(pcs), 1);
          we_cnt = 0;
        end else if (mem_addr != pa) begin
          chk(0, "R2 address moved during pulse", int'(mem_addr), int'(pa));
        end
        if (hz_left > 0) chk(0, "R7 strobe fell inside release window", hz_left, 0);
        if (mem_dq !== cur_wdata) chk(0, "R2 R6 bus byte during pulse", int'(mem_dq), int'(cur_wdata));
        dstab  = (pw && mem_dq == pdq) ? dstab + 1 : 1;
        we_cnt = we_cnt + 1;
      end else if (pw) begin
        chk(we_cnt >= WP_C, "R3 write pulse width", we_cnt, WP_C);
        chk(dstab >= DW_C, "R3 data stable before strobe rise", dstab, DW_C);
        mem[int'(pa)] = pdq;
      end
      if (hz_left > 0) hz_left = hz_left - 1;
      if (rd) begin
        rd_cnt = (pr && mem_addr == pa) ? rd_cnt + 1 : 1;
      end else if (pr) begin
        chk(rd_cnt >= RC_C, "R5 read cycle length", rd_cnt, RC_C);
        hz_left = HZ_C - 1;
      end
      mdl_drv = rd && (rd_cnt >= ACC_C);
      mdl_val = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
      pw = wr; pr = rd; pcs = cs; pa = mem_addr; pdq = mem_dq;
    end
  end

  function automatic logic [16:0] addr_of(int k);
    if (k == 17) return 17'h00000;
    if (k == 18) return 17'h1FFFF;
    return 17'(1) << k;
  endfunction

  function automatic logic [7:0] data_of(logic [16:0] a, bit alt);
    logic [6:0] h;
    h = a[7:1] ^ a[16:10] ^ (alt ? 7'h2A : 7'h00);
    return {h, 1'b1};
  endfunction

  task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) cur_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      #1;
      lat++;
      if (req_ready && !rsp_done) chk(0, "R8 ready before completion", lat, 0);
    end while (!rsp_done && lat < 1000);
    @(posedge clk);
    #1 chk(rsp_done == 1'b0, "R8 completion pulse lasts one clock", int'(rsp_done), 0);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 200000) begin
      @(posedge clk);
      wd++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", wd, 200000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && !mem_cs2 && mem_oe_n && mem_we_n, "R1 reset pin levels",
        {mem_cs_n, mem_cs2, mem_oe_n, mem_we_n}, 4'b1011);
    chk(req_ready && !rsp_done, "R1 reset handshake", {req_ready, rsp_done}, 2'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Write sweep with nothing pending: exact latency.
    for (int k = 0; k < 19; k++) begin
      do_op(1'b1, addr_of(k), data_of(addr_of(k), 1'b0), lat);
      chk(lat == WR_LAT, "R4 write completion latency", lat, WR_LAT);
    end
    // Read sweep: latency and returned byte.
    for (int k = 0; k < 19; k++) begin
      do_op(1'b0, addr_of(k), 8'h00, lat);
      chk(lat == RD_C, "R5 read completion latency", lat, RD_C);
      chk(rsp_rdata == data_of(addr_of(k), 1'b0), "R5 R6 read byte", int'(rsp_rdata),
          int'(data_of(addr_of(k), 1'b0)));
    end
    // Read, then write straight away, then read back.
    for (int k = 0; k < 19; k++) begin
      do_op(1'b0, addr_of(k), 8'h00, lat);
      do_op(1'b1, addr_of(k), data_of(addr_of(k), 1'b1), lat);
      chk(lat > WR_LAT, "R7 write after read waits for release", lat, WR_LAT + 1);
      do_op(1'b0, addr_of(k), 8'h00, lat);
      chk(rsp_rdata == data_of(addr_of(k), 1'b1), "R2 overwritten byte read back", int'(rsp_rdata),
          int'(data_of(addr_of(k), 1'b1)));
    end
    repeat (4) @(negedge clk);
    chk(req_ready && mem_cs_n && !mem_cs2, "R1 standby after traffic", int'(mem_cs2), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule